// File: doc/BRIEF.md
# Program-Space Data Window Mapper

This block sits between a core's data-side load/store port and two memories: an ordinary 16-bit data RAM and a 24-bit-wide program memory. Data addresses in the lower half of the 64 KB data space go straight to the data RAM. Addresses in the upper half form a read-only window onto program memory. An 8-bit page register chooses which 16K-word region of program space the window shows.

A window read returns only the low 16 bits of the selected 24-bit program word. It takes one more cycle than a data RAM read, and the block lowers its ready output during that extra cycle. A write aimed at the window does nothing to either memory and raises a one-cycle fault pulse.

Writes to the page register apply to accesses accepted after the write. They never change an access that is already stalled.

Top module: `psw_window_map`

## Requirements
- R1: After reset the page register holds 0, `acc_ready` is 1, and `rsp_valid`, `pm_en` and `wr_fault` are 0.
- R2: An accepted access with `acc_addr[15]`=0 drives `ram_en` in the same cycle, with `ram_addr`=`acc_addr[14:1]` and `ram_we`=`acc_write`. Byte enables are 2'b11 for a word access. For a byte access they are 2'b01 on an even address and 2'b10 on an odd address. A byte write copies `acc_wdata[7:0]` onto both lanes. A read returns `rsp_valid` with the RAM word one cycle after acceptance.
- R3: An accepted read with `acc_addr[15]`=1 drives `pm_en` in the next cycle, with `pm_addr` = {page, `acc_addr[14:1]`}. Two cycles after acceptance it asserts `rsp_valid` with `rsp_data` = `pm_rdata[15:0]`. Bits [23:16] never reach `rsp_data`.
- R4: During the cycle in which `pm_en` is high, `acc_ready` is 0. A request presented in that cycle is ignored: no RAM or program-memory access and no response.
- R5: A byte read on either path returns the word's bits [7:0] for an even address and bits [15:8] for an odd address, zero-extended to 16 bits.
- R6: An accepted write with `acc_addr[15]`=1 raises `wr_fault` for exactly one cycle, in the cycle after acceptance. It causes no RAM access, no program-memory access and no response.
- R7: A page write takes effect for accesses accepted after the clock edge that stores it. A page write made while a window read is stalled does not change that read's address.
- R8: For a word access, `acc_addr[0]` has no effect on the address or on the returned data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Data-side access request |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_byte | input | 1 | 1 = byte access, 0 = word access |
| acc_addr | input | 16 | Data-space byte address |
| acc_wdata | input | 16 | Write data (byte writes use bits [7:0]) |
| acc_ready | output | 1 | Request accepted when high together with acc_valid |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 16 | Read data, zero-extended for byte reads |
| wr_fault | output | 1 | One-cycle pulse for a write into the window |
| page_wr_en | input | 1 | Page register write strobe |
| page_wr_data | input | 8 | New page value |
| ram_en | output | 1 | Data RAM access strobe |
| ram_we | output | 1 | Data RAM write enable |
| ram_be | output | 2 | Data RAM byte enables (bit 1 = high byte) |
| ram_addr | output | 15 | Data RAM word address |
| ram_wdata | output | 16 | Data RAM write data |
| ram_rdata | input | 16 | Data RAM read data, one cycle after ram_en |
| pm_en | output | 1 | Program memory read strobe |
| pm_addr | output | 22 | Program memory word address |
| pm_rdata | input | 24 | Program memory word, one cycle after pm_en |

## Verification
All 256 page values are swept with window offsets at both ends and the middle of the window, so a wrong or shifted page field shows up. One page is then swept across every word offset of the window, which separates address bit slicing errors from page errors. Byte reads at even and odd addresses on both paths show whether the lane selection is swapped or missing. Word reads with bit 0 set, a request and a page write injected during the stall, and a write into the window probe the ignore and fault cases.

// File: rtl/psw_pkg.sv
package psw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DATA  = 2'd2
  } win_state_e;
endpackage

// File: rtl/psw_rst_sync.sv
module psw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/psw_page_reg.sv
module psw_page_reg #(
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_data,
  output logic [PAGE_W-1:0] page_q
);
  logic [PAGE_W-1:0] page_d;

  always_comb begin
    page_d = page_q;
    if (wr_en) page_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) page_q <= '0;
    else        page_q <= page_d;
  end

  // R7
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(page_q) |-> $past(wr_en));
endmodule

// File: rtl/psw_addr_decode.sv
module psw_addr_decode #(
  parameter int ADDR_W = 16,
  localparam int WIDX_W = ADDR_W - 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              byte_acc,
  output logic              in_window,
  output logic [WIDX_W-1:0] ram_word,
  output logic [WIDX_W-2:0] win_word,
  output logic              lane_hi,
  output logic [1:0]        be
);
  always_comb begin
    in_window = addr[ADDR_W-1];
    ram_word  = addr[ADDR_W-1:1];
    win_word  = addr[ADDR_W-2:1];
    lane_hi   = byte_acc & addr[0];
    if (!byte_acc)    be = 2'b11;
    else if (addr[0]) be = 2'b10;
    else              be = 2'b01;
  end
endmodule

// File: rtl/psw_lane_sel.sv
module psw_lane_sel #(
  parameter int DATA_W = 16,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic [DATA_W-1:0] word_in,
  input  logic              byte_sel,
  input  logic              hi_sel,
  output logic [DATA_W-1:0] data_out
);
  logic [HALF_W-1:0] lane;

  assign lane = hi_sel ? word_in[DATA_W-1:HALF_W] : word_in[HALF_W-1:0];

  always_comb begin
    if (byte_sel) data_out = {{HALF_W{1'b0}}, lane};
    else          data_out = word_in;
  end
endmodule

// File: rtl/psw_window_map.sv
module psw_window_map #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int PWORD_W = 24,
  parameter int PAGE_W  = 8,
  localparam int RAM_AW = ADDR_W - 1,
  localparam int WIN_AW = ADDR_W - 2,
  localparam int PM_AW  = PAGE_W + WIN_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic              acc_byte,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic              acc_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              wr_fault,
  input  logic              page_wr_en,
  input  logic [PAGE_W-1:0] page_wr_data,
  output logic              ram_en,
  output logic              ram_we,
  output logic [1:0]        ram_be,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              pm_en,
  output logic [PM_AW-1:0]  pm_addr,
  input  logic [PWORD_W-1:0] pm_rdata
);
  import psw_pkg::*;

  localparam int HALF_W = DATA_W / 2;

  logic              rst_sync_n;
  logic [PAGE_W-1:0] page_q;
  logic              in_window;
  logic [RAM_AW-1:0] ram_word;
  logic [WIN_AW-1:0] win_word;
  logic              lane_hi;
  logic [1:0]        be;

  win_state_e        state_q, state_d;
  logic [PM_AW-1:0]  hold_addr_q;
  logic              hold_byte_q, hold_hi_q;
  logic              ram_pend_q, ram_pend_d;
  logic              ram_byte_q, ram_hi_q;
  logic              fault_q, fault_d;

  logic              acc_fire, win_rd, win_wr, hold_en;
  logic [DATA_W-1:0] sel_word;
  logic              sel_byte, sel_hi;

  psw_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  psw_page_reg #(.PAGE_W(PAGE_W)) u_page (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(page_wr_en),
    .wr_data(page_wr_data), .page_q(page_q)
  );

  psw_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(acc_addr), .byte_acc(acc_byte), .in_window(in_window),
    .ram_word(ram_word), .win_word(win_word), .lane_hi(lane_hi), .be(be)
  );

  // Request side
  always_comb begin
    acc_ready = (state_q != ST_ISSUE);
    acc_fire  = acc_valid & acc_ready;
    win_rd    = acc_fire & in_window & ~acc_write;
    win_wr    = acc_fire & in_window & acc_write;
    hold_en   = win_rd;
    ram_en    = acc_fire & ~in_window;
    ram_we    = acc_write;
    ram_be    = be;
    ram_addr  = ram_word;
    ram_wdata = acc_byte ? {acc_wdata[HALF_W-1:0], acc_wdata[HALF_W-1:0]} : acc_wdata;
  end

  // Next state
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_ISSUE: state_d = ST_DATA;
      default:  state_d = win_rd ? ST_ISSUE : ST_IDLE;
    endcase
    ram_pend_d = ram_en & ~acc_write;
    fault_d    = win_wr;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q    <= ST_IDLE;
      ram_pend_q <= 1'b0;
      ram_byte_q <= 1'b0;
      ram_hi_q   <= 1'b0;
      fault_q    <= 1'b0;
    end else begin
      state_q    <= state_d;
      ram_pend_q <= ram_pend_d;
      ram_byte_q <= acc_byte;
      ram_hi_q   <= lane_hi;
      fault_q    <= fault_d;
    end
  end

  // Held window access, loaded only on acceptance
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      hold_addr_q <= '0;
      hold_byte_q <= 1'b0;
      hold_hi_q   <= 1'b0;
    end else if (hold_en) begin
      hold_addr_q <= {page_q, win_word};
      hold_byte_q <= acc_byte;
      hold_hi_q   <= lane_hi;
    end
  end

  // Program memory side and response
  always_comb begin
    pm_en     = (state_q == ST_ISSUE);
    pm_addr   = hold_addr_q;
    wr_fault  = fault_q;
    rsp_valid = ram_pend_q | (state_q == ST_DATA);
    if (state_q == ST_DATA) begin
      sel_word = pm_rdata[DATA_W-1:0];
      sel_byte = hold_byte_q;
      sel_hi   = hold_hi_q;
    end else begin
      sel_word = ram_rdata;
      sel_byte = ram_byte_q;
      sel_hi   = ram_hi_q;
    end
  end

  psw_lane_sel #(.DATA_W(DATA_W)) u_lane (
    .word_in(sel_word), .byte_sel(sel_byte), .hi_sel(sel_hi), .data_out(rsp_data)
  );

  // R2
  ram_side_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ram_en |-> !acc_addr[ADDR_W-1] && !pm_en);

  // R3
  pm_addr_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pm_en |-> pm_addr == {$past(page_q), $past(acc_addr[ADDR_W-2:1])});

  // R3
  pm_rsp_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pm_en |=> rsp_valid && !ram_pend_q);

  // R3
  pm_low_only_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_DATA) && !hold_byte_q |-> rsp_data == DATA_W'(pm_rdata));

  // R4
  stall_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pm_en |-> !acc_ready && !ram_en);

  // R6
  fault_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_fault |-> $past(acc_valid && acc_write && acc_addr[ADDR_W-1]) && !rsp_valid && !pm_en);

  // R6
  fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_fault |=> !wr_fault || $past(acc_valid && acc_write && acc_addr[ADDR_W-1]));
endmodule

// File: tb/tb_psw_window_map.sv
module tb_psw_window_map;
  logic        clk;
  logic        rst_n;
  logic        acc_valid, acc_write, acc_byte;
  logic [15:0] acc_addr, acc_wdata;
  logic        acc_ready, rsp_valid, wr_fault;
  logic [15:0] rsp_data;
  logic        page_wr_en;
  logic [7:0]  page_wr_data;
  logic        ram_en, ram_we;
  logic [1:0]  ram_be;
  logic [14:0] ram_addr;
  logic [15:0] ram_wdata, ram_rdata;
  logic        pm_en;
  logic [21:0] pm_addr;
  logic [23:0] pm_rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [7:0]  cur_page;
  logic [15:0] ram_mem [256];
  logic [15:0] ram_exp [256];

  psw_window_map dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_byte(acc_byte), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .acc_ready(acc_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .wr_fault(wr_fault), .page_wr_en(page_wr_en), .page_wr_data(page_wr_data),
    .ram_en(ram_en), .ram_we(ram_we), .ram_be(ram_be), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .pm_en(pm_en),
    .pm_addr(pm_addr), .pm_rdata(pm_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [23:0] pm_word(logic [21:0] a);
    logic [23:0] v;
    v = {2'b00, a} * 24'd40503 + 24'h3C15A7;
    return v ^ {a[7:0], 16'h0000};
  endfunction

  // Memory models: one cycle read latency
  always @(posedge clk) begin
    if (pm_en) pm_rdata <= pm_word(pm_addr);
    if (ram_en) begin
      if (ram_we) begin
        if (ram_be[0]) ram_mem[ram_addr[7:0]][7:0]  <= ram_wdata[7:0];
        if (ram_be[1]) ram_mem[ram_addr[7:0]][15:8] <= ram_wdata[15:8];
      end else begin
        ram_rdata <= ram_mem[ram_addr[7:0]];
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] lane(logic [15:0] w, logic byt, logic odd);
    if (!byt) return w;
    return odd ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
  endfunction

  task automatic idle_in();
    acc_valid = 0; acc_write = 0; acc_byte = 0; acc_addr = '0; acc_wdata = '0;
  endtask

  task automatic set_page(logic [7:0] p);
    @(negedge clk);
    page_wr_en = 1; page_wr_data = p;
    @(negedge clk);
    page_wr_en = 0;
    cur_page = p;
  endtask

  // Window read; inject=1 drives a request and a page write during the stall
  task automatic win_read(logic [15:0] a, logic byt, bit inject, string req);
    logic [21:0] ea;
    logic [15:0] ed;
    ea = {cur_page, a[14:1]};
    ed = lane(pm_word(ea)[15:0], byt, a[0]);
    @(negedge clk);
    chk("R4 ready before", {31'd0, acc_ready}, 1);
    acc_valid = 1; acc_write = 0; acc_byte = byt; acc_addr = a;
    @(negedge clk);
    idle_in();
    chk({req, " pm_en"}, {31'd0, pm_en}, 1);
    chk({req, " pm_addr"}, {10'd0, pm_addr}, {10'd0, ea});
    if (inject) begin
      acc_valid = 1; acc_addr = 16'h0042;
      page_wr_en = 1; page_wr_data = ~cur_page;
      #1;
      chk("R4 stall ready", {31'd0, acc_ready}, 0);
      chk("R4 stall ram_en", {31'd0, ram_en}, 0);
    end
    @(negedge clk);
    if (inject) begin
      idle_in(); page_wr_en = 0; cur_page = ~cur_page;
    end
    chk({req, " rsp_valid"}, {31'd0, rsp_valid}, 1);
    chk({req, " rsp_data"}, {16'd0, rsp_data}, {16'd0, ed});
    if (inject) begin
      @(negedge clk);
      chk("R4 ignored no rsp", {31'd0, rsp_valid}, 0);
    end
  endtask

  task automatic ram_write(logic [15:0] a, logic byt, logic [15:0] d);
    logic [1:0] eb;
    logic [15:0] wd;
    eb = !byt ? 2'b11 : (a[0] ? 2'b10 : 2'b01);
    wd = byt ? {d[7:0], d[7:0]} : d;
    @(negedge clk);
    acc_valid = 1; acc_write = 1; acc_byte = byt; acc_addr = a; acc_wdata = d;
    #1;
    chk("R2 wr ram_en", {31'd0, ram_en}, 1);
    chk("R2 wr be", {30'd0, ram_be}, {30'd0, eb});
    chk("R2 wr addr", {17'd0, ram_addr}, {17'd0, a[15:1]});
    if (eb[0]) ram_exp[a[8:1]][7:0]  = wd[7:0];
    if (eb[1]) ram_exp[a[8:1]][15:8] = wd[15:8];
    @(negedge clk);
    idle_in();
  endtask

  task automatic ram_read(logic [15:0] a, logic byt, string req);
    @(negedge clk);
    acc_valid = 1; acc_write = 0; acc_byte = byt; acc_addr = a;
    #1;
    chk("R2 rd ram_en", {31'd0, ram_en}, 1);
    chk("R2 rd pm_en", {31'd0, pm_en}, 0);
    @(negedge clk);
    idle_in();
    chk({req, " rsp_valid"}, {31'd0, rsp_valid}, 1);
    chk({req, " rsp_data"}, {16'd0, rsp_data}, {16'd0, lane(ram_exp[a[8:1]], byt, a[0])});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      ram_mem[i] = 16'h0000; ram_exp[i] = 16'h0000;
    end
    idle_in();
    page_wr_en = 0; page_wr_data = '0; cur_page = 8'h00;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 ready", {31'd0, acc_ready}, 1);
    chk("R1 rsp_valid", {31'd0, rsp_valid}, 0);
    chk("R1 pm_en", {31'd0, pm_en}, 0);
    chk("R1 wr_fault", {31'd0, wr_fault}, 0);
    win_read(16'h8000, 0, 0, "R1 page zero");
    win_read(16'hFFFE, 0, 0, "R1 page zero top");

    // R7 every page value, window edges and middle
    for (int p = 0; p < 256; p++) begin
      set_page(p[7:0]);
      win_read(16'h8000, 0, 0, "R7 page sweep lo");
      win_read(16'hFFFE, 0, 0, "R7 page sweep hi");
      win_read(16'hC000 ^ {p[7:0], 8'h00} | 16'h8000, 0, 0, "R7 page sweep mid");
    end

    // R3 every word offset in one page
    set_page(8'h3C);
    for (int w = 0; w < 16384; w++)
      win_read({1'b1, w[13:0], 1'b0}, 0, 0, "R3 offset sweep");

    // R5 byte reads in the window, R8 odd word address
    set_page(8'hA7);
    for (int w = 0; w < 64; w++) begin
      win_read({1'b1, w[13:0] * 14'd257, 1'b0}, 1, 0, "R5 win byte even");
      win_read({1'b1, w[13:0] * 14'd257, 1'b1}, 1, 0, "R5 win byte odd");
      win_read({1'b1, w[13:0] * 14'd257, 1'b1}, 0, 0, "R8 win word odd addr");
    end

    // R4 and R7 injection during stall
    win_read(16'h9234, 0, 1, "R4 R7 inject");
    win_read(16'h9234, 0, 0, "R7 new page used");
    win_read(16'hA001, 1, 1, "R4 R7 inject byte");

    // R2 RAM path, R5 byte lanes, R8
    for (int i = 0; i < 32; i++)
      ram_write({7'd0, i[7:0], 1'b0}, 0, 16'h1111 * i[15:0] ^ 16'hA5C3);
    for (int i = 0; i < 32; i++)
      ram_read({7'd0, i[7:0], 1'b0}, 0, "R2 ram word");
    ram_write(16'h0011, 1, 16'hFF5A);
    ram_write(16'h0020, 1, 16'h00C7);
    for (int i = 0; i < 32; i++) begin
      ram_read({7'd0, i[7:0], 1'b0}, 1, "R5 ram byte even");
      ram_read({7'd0, i[7:0], 1'b1}, 1, "R5 ram byte odd");
      ram_read({7'd0, i[7:0], 1'b1}, 0, "R8 ram word odd addr");
    end

    // R6 write into window
    @(negedge clk);
    acc_valid = 1; acc_write = 1; acc_byte = 0; acc_addr = 16'h9000; acc_wdata = 16'hDEAD;
    #1;
    chk("R6 no ram_en", {31'd0, ram_en}, 0);
    @(negedge clk);
    idle_in();
    chk("R6 fault pulse", {31'd0, wr_fault}, 1);
    chk("R6 no pm_en", {31'd0, pm_en}, 0);
    chk("R6 no rsp", {31'd0, rsp_valid}, 0);
    @(negedge clk);
    chk("R6 fault one cycle", {31'd0, wr_fault}, 0);
    chk("R6 no late pm_en", {31'd0, pm_en}, 0);
    ram_read(16'h0000, 0, "R6 ram untouched");
    win_read(16'h9000, 0, 0, "R6 window still readable");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule